// File: doc/BRIEF.md
# Key-Sequenced 64-bit Watchdog Timer

This block is a memory-mapped watchdog built around a 64-bit up-counter. The counter is kept as two 32-bit halves, and the timeout limit is held as two 32-bit halves as well. Software loads the limit, the starting count and two small configuration fields while the block is idle. It then arms the block by writing an opening key and a commit key into the watchdog control word.

Once armed, every configuration register is frozen. The only thing software can still do is service the watchdog by writing the same key pair again, which restarts the count from zero. A count that reaches the limit, or any key written out of turn, ends in a multi-cycle reset request and a sticky expiry flag. The block then stays expired until its own reset input is asserted.

The bus is a single-cycle 32-bit register port. Reads are combinational from the addressed register.

Top module: `keyed_wdog`

## Requirements
- R1: After reset every register reads zero, the block is idle and `sys_rst_req` is low.
- R2: While idle, the registers are writable and read back as follows. 0x10 and 0x14 hold the low and high count halves. 0x18 and 0x1C hold the low and high limit halves. 0x20 holds the run mode in bits 7:6, with all other bits reading 0. 0x24 holds two half-enable bits in bits 1:0 and a mode field in bits 3:2, with all other bits reading 0. Any other offset reads 0 and ignores writes.
- R3: The watchdog control word sits at 0x28, with the key in bits 31:16, enable in bit 14 and the expiry flag in bit 15. While idle, writing key 0xA5C6 with bit 14 set opens the block, and bit 14 then reads 1. Any other write to 0x28 while idle is ignored and raises no reset. In the opened state, key 0xDA7E moves the block to active.
- R4: The counter adds one per clock only while the block is active or servicing and the configuration is valid. Valid means 0x24 bits 1:0 are both 1, 0x24 bits 3:2 equal 2, and 0x20 bits 7:6 are non-zero. Counting starts from the value loaded while idle and carries from the low half into the high half.
- R5: While active, key 0xA5C6 enters service and the count keeps running. A following key 0xDA7E clears the count to zero and returns the block to active. The cycle may be repeated.
- R6: From the opened state onward, writes to 0x10 through 0x24 are ignored. At 0x28 only the key field acts, and the enable bit stays 1 even when written 0.
- R7: While opened, active or servicing, any key other than the one expected next moves the block to expired at the next clock edge and raises `sys_rst_req`.
- R8: When the counter equals the limit while counting, the block expires at the next edge. The count then holds at the limit, and 0x28 reads with bits 15 and 14 set. In the same cycle, expiry takes priority over a commit key.
- R9: `sys_rst_req` is a registered pulse exactly `PULSE_LEN` cycles long, starting at the expiry edge. The expired state ignores all writes, and only `rst_n` leaves it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_en | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of a read access |
| sys_rst_req | output | 1 | System reset request pulse |

## Verification
If the key state machine holds a wrong state, the next key write shows it. Either `sys_rst_req` rises one edge after that write when it should not, or it stays low when it should rise, and the enable and flag bits of the control word show the error on the following read. A wrong count or a wrong gating decision shows up in back-to-back reads of the count halves, which must differ by exactly one. It also shows up in the edge at which the reset pulse first appears, which the bench pins to the exact cycle after arming. A late or lengthened pulse is caught by counting its cycles at the port.

// File: rtl/keyed_wdog_pkg.sv
package keyed_wdog_pkg;

  // register byte offsets
  localparam logic [7:0] OFS_CNT_LO = 8'h10;
  localparam logic [7:0] OFS_CNT_HI = 8'h14;
  localparam logic [7:0] OFS_PER_LO = 8'h18;
  localparam logic [7:0] OFS_PER_HI = 8'h1C;
  localparam logic [7:0] OFS_TCTL   = 8'h20;
  localparam logic [7:0] OFS_GCTL   = 8'h24;
  localparam logic [7:0] OFS_WCTL   = 8'h28;

  // control word fields
  localparam int WC_EN_BIT   = 14;
  localparam int WC_FLAG_BIT = 15;
  localparam int WC_KEY_LSB  = 16;
  localparam int TC_MODE_LSB = 6;

  localparam logic [15:0] KEY_OPEN   = 16'hA5C6;
  localparam logic [15:0] KEY_COMMIT = 16'hDA7E;
  localparam logic [1:0]  GC_MODE_WDOG = 2'd2;

  typedef enum logic [2:0] {
    WD_IDLE = 3'd0,
    WD_OPEN = 3'd1,
    WD_LIVE = 3'd2,
    WD_SVC  = 3'd3,
    WD_TRIP = 3'd4
  } wd_state_e;

endpackage

// File: rtl/keyed_wdog_fsm.sv
module keyed_wdog_fsm
  import keyed_wdog_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        key_wr,
  input  logic [15:0] key_val,
  input  logic        en_bit,
  input  logic        expire,
  output wd_state_e   state,
  output logic        pet,
  output logic        trip
);

  wd_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    pet     = 1'b0;
    trip    = 1'b0;
    case (state_q)
      WD_IDLE: begin
        if (key_wr && en_bit && (key_val == KEY_OPEN)) state_d = WD_OPEN;
      end
      WD_OPEN: begin
        if (key_wr) begin
          if (key_val == KEY_COMMIT) state_d = WD_LIVE;
          else begin
            state_d = WD_TRIP;
            trip    = 1'b1;
          end
        end
      end
      WD_LIVE: begin
        if (expire) begin
          state_d = WD_TRIP;
          trip    = 1'b1;
        end else if (key_wr) begin
          if (key_val == KEY_OPEN) state_d = WD_SVC;
          else begin
            state_d = WD_TRIP;
            trip    = 1'b1;
          end
        end
      end
      WD_SVC: begin
        // expiry wins over a commit key landing in the same cycle
        if (expire) begin
          state_d = WD_TRIP;
          trip    = 1'b1;
        end else if (key_wr) begin
          if (key_val == KEY_COMMIT) begin
            state_d = WD_LIVE;
            pet     = 1'b1;
          end else begin
            state_d = WD_TRIP;
            trip    = 1'b1;
          end
        end
      end
      WD_TRIP: state_d = WD_TRIP;
      default: state_d = WD_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= WD_IDLE;
    else        state_q <= state_d;
  end

  assign state = state_q;

endmodule

// File: rtl/keyed_wdog_ctr.sv
module keyed_wdog_ctr #(
  parameter int HALF_W = 32,
  parameter int NHALF  = 2,
  localparam int CNT_W = HALF_W * NHALF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              clr,
  input  logic [NHALF-1:0]  wr_half,
  input  logic [HALF_W-1:0] wr_data,
  input  logic [CNT_W-1:0]  limit,
  output logic [CNT_W-1:0]  count,
  output logic              at_limit
);

  logic [CNT_W-1:0] cnt_w;
  logic [CNT_W-1:0] cnt_inc;
  logic             step;

  assign at_limit = (cnt_w == limit);
  assign step     = run && !at_limit;
  assign cnt_inc  = cnt_w + {{(CNT_W-1){1'b0}}, 1'b1};

  for (genvar h = 0; h < NHALF; h++) begin : g_half
    logic [HALF_W-1:0] half_q, half_d;
    logic              half_ld;

    always_comb begin
      half_ld = clr || step || wr_half[h];
      if (clr)             half_d = '0;
      else if (wr_half[h]) half_d = wr_data;
      else                 half_d = cnt_inc[h*HALF_W +: HALF_W];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       half_q <= '0;
      else if (half_ld) half_q <= half_d;
    end

    assign cnt_w[h*HALF_W +: HALF_W] = half_q;
  end

  assign count = cnt_w;

endmodule

// File: rtl/keyed_wdog_pulse.sv
module keyed_wdog_pulse #(
  parameter int LEN = 4,
  localparam int CW = (LEN > 1) ? $clog2(LEN) : 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  output logic pulse
);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          out_q, out_d;

  always_comb begin
    cnt_d = cnt_q;
    out_d = out_q;
    if (fire) begin
      out_d = 1'b1;
      cnt_d = CW'(LEN - 1);
    end else if (out_q) begin
      if (cnt_q != '0) cnt_d = cnt_q - 1'b1;
      else             out_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      out_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      out_q <= out_d;
    end
  end

  assign pulse = out_q;

endmodule

// File: rtl/keyed_wdog.sv
module keyed_wdog
  import keyed_wdog_pkg::*;
#(
  parameter int ADDR_W    = 6,
  parameter int PULSE_LEN = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              sys_rst_req
);

  localparam int HALF_W = 32;
  localparam int NHALF  = 2;
  localparam int CNT_W  = HALF_W * NHALF;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rsync_q;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_core_n = rsync_q[1];

  // decode
  wd_state_e         state;
  logic              wr, cfg_wr, armed, key_wr;
  logic              run, cfg_ok, expire, pet, trip, at_limit;
  logic [NHALF-1:0]  cnt_wr;
  logic [CNT_W-1:0]  period, count;
  logic [1:0]        tctl_q;
  logic [3:0]        gctl_q;
  logic [15:0]       key_val;

  assign wr      = bus_en && bus_we;
  assign armed   = (state != WD_IDLE);
  assign cfg_wr  = wr && !armed;
  assign key_wr  = wr && (bus_addr == ADDR_W'(OFS_WCTL));
  assign key_val = bus_wdata[WC_KEY_LSB +: 16];

  for (genvar h = 0; h < NHALF; h++) begin : g_per
    logic              ld;
    logic [HALF_W-1:0] q;
    assign ld = cfg_wr && (bus_addr == ADDR_W'(OFS_PER_LO + 8'(4*h)));
    always_ff @(posedge clk or negedge rst_core_n) begin
      if (!rst_core_n) q <= '0;
      else if (ld)     q <= bus_wdata;
    end
    assign period[h*HALF_W +: HALF_W] = q;
    assign cnt_wr[h] = cfg_wr && (bus_addr == ADDR_W'(OFS_CNT_LO + 8'(4*h)));
  end

  logic tctl_ld, gctl_ld;
  assign tctl_ld = cfg_wr && (bus_addr == ADDR_W'(OFS_TCTL));
  assign gctl_ld = cfg_wr && (bus_addr == ADDR_W'(OFS_GCTL));

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n)  tctl_q <= 2'b00;
    else if (tctl_ld) tctl_q <= bus_wdata[TC_MODE_LSB +: 2];
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n)  gctl_q <= 4'h0;
    else if (gctl_ld) gctl_q <= bus_wdata[3:0];
  end

  assign cfg_ok = (gctl_q[1:0] == 2'b11) && (gctl_q[3:2] == GC_MODE_WDOG) &&
                  (tctl_q != 2'b00);
  assign run    = ((state == WD_LIVE) || (state == WD_SVC)) && cfg_ok;
  assign expire = run && at_limit;

  keyed_wdog_fsm u_fsm (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .key_wr  (key_wr),
    .key_val (key_val),
    .en_bit  (bus_wdata[WC_EN_BIT]),
    .expire  (expire),
    .state   (state),
    .pet     (pet),
    .trip    (trip)
  );

  keyed_wdog_ctr #(.HALF_W(HALF_W), .NHALF(NHALF)) u_ctr (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .run      (run),
    .clr      (pet),
    .wr_half  (cnt_wr),
    .wr_data  (bus_wdata),
    .limit    (period),
    .count    (count),
    .at_limit (at_limit)
  );

  keyed_wdog_pulse #(.LEN(PULSE_LEN)) u_pulse (
    .clk   (clk),
    .rst_n (rst_core_n),
    .fire  (trip),
    .pulse (sys_rst_req)
  );

  // read path
  always_comb begin
    bus_rdata = '0;
    if (bus_en && !bus_we) begin
      case (bus_addr)
        ADDR_W'(OFS_CNT_LO): bus_rdata = count[31:0];
        ADDR_W'(OFS_CNT_HI): bus_rdata = count[63:32];
        ADDR_W'(OFS_PER_LO): bus_rdata = period[31:0];
        ADDR_W'(OFS_PER_HI): bus_rdata = period[63:32];
        ADDR_W'(OFS_TCTL):   bus_rdata[TC_MODE_LSB +: 2] = tctl_q;
        ADDR_W'(OFS_GCTL):   bus_rdata[3:0] = gctl_q;
        ADDR_W'(OFS_WCTL): begin
          bus_rdata[WC_EN_BIT]   = armed;
          bus_rdata[WC_FLAG_BIT] = (state == WD_TRIP);
        end
        default: bus_rdata = '0;
      endcase
    end
  end

endmodule

// File: rtl/keyed_wdog_chk.sv
module keyed_wdog_chk
  import keyed_wdog_pkg::*;
#(
  parameter int PULSE_LEN = 4,
  parameter int CNT_W     = 64
) (
  input logic             clk,
  input logic             rst_n,
  input wd_state_e        state,
  input logic             armed,
  input logic             run,
  input logic             at_limit,
  input logic             key_wr,
  input logic [15:0]      key_val,
  input logic [CNT_W-1:0] count,
  input logic [CNT_W-1:0] period,
  input logic [5:0]       cfg_bits,
  input logic             sys_rst_req
);

  logic [31:0] hi_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           hi_run <= '0;
    else if (sys_rst_req) hi_run <= hi_run + 1'b1;
    else                  hi_run <= '0;
  end

  p_idle_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == WD_IDLE) |-> !sys_rst_req);

  p_count_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !at_limit && !key_wr) |=> (count == $past(count) + 1'b1));

  p_pet_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == WD_SVC) && key_wr && (key_val == KEY_COMMIT) && !(run && at_limit))
      |=> (count == '0));

  p_cfg_locked_r6: assert property (@(posedge clk) disable iff (!rst_n)
    armed |=> ($stable(period) && $stable(cfg_bits)));

  p_cnt_frozen_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !run) |=> $stable(count));

  p_bad_key_open_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == WD_OPEN) && key_wr && (key_val != KEY_COMMIT))
      |=> (sys_rst_req && (state == WD_TRIP)));

  p_bad_key_live_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == WD_LIVE) && !(run && at_limit) && key_wr && (key_val != KEY_OPEN))
      |=> (sys_rst_req && (state == WD_TRIP)));

  p_timeout_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (run && at_limit) |=> (sys_rst_req && (state == WD_TRIP)));

  p_trip_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (state == WD_TRIP) |=> (state == WD_TRIP));

  p_req_in_trip_r9: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst_req |-> (state == WD_TRIP));

  p_pulse_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst_req |-> (hi_run < PULSE_LEN));

endmodule

bind keyed_wdog keyed_wdog_chk #(.PULSE_LEN(PULSE_LEN), .CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .state       (state),
  .armed       (armed),
  .run         (run),
  .at_limit    (at_limit),
  .key_wr      (key_wr),
  .key_val     (key_val),
  .count       (count),
  .period      (period),
  .cfg_bits    ({tctl_q, gctl_q}),
  .sys_rst_req (sys_rst_req)
);

// File: tb/keyed_wdog_test.sv
module keyed_wdog_test;
  import keyed_wdog_pkg::*;

  localparam int PULSE = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_en = 1'b0;
  logic        bus_we = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        sys_rst_req;

  always #2 clk = ~clk;

  keyed_wdog #(.ADDR_W(6), .PULSE_LEN(PULSE)) uut (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .sys_rst_req(sys_rst_req)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;
  logic [31:0] r, r2;

  // bench model of idle-state register contents
  logic [63:0] m_cnt, m_per;
  logic [1:0]  m_t;
  logic [3:0]  m_g;

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic report();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    end
  endtask

  task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b1; bus_addr = a[5:0]; bus_wdata = d;
    @(posedge clk);
    #1;
    bus_en = 1'b0; bus_we = 1'b0;
  endtask

  task automatic bus_rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b0; bus_addr = a[5:0];
    #1;
    d = bus_rdata;
    bus_en = 1'b0;
  endtask

  task automatic do_reset();
    bus_en = 1'b0; bus_we = 1'b0;
    rst_n = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    m_cnt = '0; m_per = '0; m_t = '0; m_g = '0;
  endtask

  function automatic logic [31:0] key_word(input logic [15:0] k, input logic en);
    return {k, 1'b0, en, 14'h0};
  endfunction

  function automatic logic [7:0] addr_pool(input int unsigned i);
    case (i)
      0: return 8'h10;  1: return 8'h14;  2: return 8'h18;
      3: return 8'h1C;  4: return 8'h20;  5: return 8'h24;
      6: return 8'h28;  7: return 8'h00;  default: return 8'h2C;
    endcase
  endfunction

  function automatic logic [31:0] exp_rd(input logic [7:0] a);
    case (a)
      8'h10: return m_cnt[31:0];
      8'h14: return m_cnt[63:32];
      8'h18: return m_per[31:0];
      8'h1C: return m_per[63:32];
      8'h20: return {24'h0, m_t, 6'h0};
      8'h24: return {28'h0, m_g};
      default: return 32'h0;
    endcase
  endfunction

  task automatic model_write(input logic [7:0] a, input logic [31:0] d);
    case (a)
      8'h10: m_cnt[31:0]  = d;
      8'h14: m_cnt[63:32] = d;
      8'h18: m_per[31:0]  = d;
      8'h1C: m_per[63:32] = d;
      8'h20: m_t = d[7:6];
      8'h24: m_g = d[3:0];
      default: ;
    endcase
  endtask

  task automatic setup(input logic [63:0] per, input logic [63:0] cnt,
                       input logic [31:0] t, input logic [31:0] g);
    bus_wr(8'h18, per[31:0]);  bus_wr(8'h1C, per[63:32]);
    bus_wr(8'h10, cnt[31:0]);  bus_wr(8'h14, cnt[63:32]);
    bus_wr(8'h20, t);          bus_wr(8'h24, g);
  endtask

  task automatic arm();
    bus_wr(8'h28, key_word(KEY_OPEN, 1'b1));
    bus_wr(8'h28, key_word(KEY_COMMIT, 1'b1));
  endtask

  // watchdog
  initial begin
    #(4 * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: run did not finish, got timeout expected completion");
    report();
    $finish;
  end

  initial begin
    int first;
    int hi;
    void'($urandom(32'h5EED_0042));
    do_reset();

    // R1: reset state
    for (int i = 0; i < 7; i++) begin
      bus_rd(addr_pool(i), r);
      check("R1", "reset readback", r, 32'h0);
    end
    check("R1", "reset req", {31'h0, sys_rst_req}, 32'h0);

    // R2 / R3: random idle writes, random non-opening keys ignored
    for (int i = 0; i < 40; i++) begin
      int unsigned pick;
      logic [7:0]  a;
      logic [31:0] d;
      pick = $urandom_range(8, 0);
      a = addr_pool(pick);
      d = $urandom();
      if (a == 8'h28 && d[31:16] == KEY_OPEN) d[31:16] = 16'h0;
      bus_wr(a, d);
      model_write(a, d);
      bus_rd(a, r);
      check("R2", "idle readback", r, exp_rd(a));
      pick = $urandom_range(8, 0);
      bus_rd(addr_pool(pick), r);
      check("R2", "idle cross read", r, exp_rd(addr_pool(pick)));
    end
    bus_rd(8'h28, r);
    check("R3", "idle key ignored ctrl", r, 32'h0);
    check("R3", "idle key no req", {31'h0, sys_rst_req}, 32'h0);

    // R3 / R6: opening, lock, enable sticks
    do_reset();
    setup(64'h100, 64'h0, 32'h80, 32'hB);
    bus_wr(8'h28, key_word(KEY_OPEN, 1'b0));
    bus_rd(8'h28, r);
    check("R3", "open without enable ignored", r, 32'h0);
    bus_wr(8'h28, key_word(KEY_OPEN, 1'b1));
    bus_rd(8'h28, r);
    check("R3", "opened enable bit", r, 32'h4000);
    bus_wr(8'h18, 32'h55); bus_wr(8'h24, 32'h0);
    bus_wr(8'h20, 32'h0);  bus_wr(8'h10, 32'h77);
    bus_rd(8'h18, r); check("R6", "limit locked", r, 32'h100);
    bus_rd(8'h24, r); check("R6", "global ctrl locked", r, 32'hB);
    bus_rd(8'h20, r); check("R6", "timer ctrl locked", r, 32'h80);
    bus_rd(8'h10, r); check("R6", "count locked", r, 32'h0);
    bus_wr(8'h28, key_word(KEY_COMMIT, 1'b0));
    bus_rd(8'h28, r);
    check("R6", "enable not clearable", r, 32'h4000);
    bus_rd(8'h10, r);
    bus_rd(8'h10, r2);
    check("R4", "active count steps", r2, r + 32'd1);
    check("R3", "no req while active", {31'h0, sys_rst_req}, 32'h0);

    // R4: carry from a preloaded count
    do_reset();
    setup(64'h5_0000_0000, 64'h0_FFFF_FFFE, 32'h40, 32'hB);
    arm();
    bus_rd(8'h10, r); check("R4", "preload start", r, 32'hFFFF_FFFE);
    bus_rd(8'h10, r); check("R4", "step low", r, 32'hFFFF_FFFF);
    bus_rd(8'h10, r); check("R4", "low wraps", r, 32'h0);
    bus_rd(8'h14, r); check("R4", "carry into high", r, 32'h1);

    // R4: gating by configuration
    do_reset();
    setup(64'd10, 64'h0, 32'h0, 32'hB);
    arm();
    repeat (30) @(posedge clk);
    bus_rd(8'h10, r); check("R4", "timer mode 0 holds count", r, 32'h0);
    check("R4", "timer mode 0 no expiry", {31'h0, sys_rst_req}, 32'h0);
    do_reset();
    setup(64'd10, 64'h0, 32'h80, 32'h7);
    arm();
    repeat (30) @(posedge clk);
    bus_rd(8'h10, r); check("R4", "global mode 1 holds count", r, 32'h0);
    bus_rd(8'h28, r); check("R4", "global mode 1 no flag", r, 32'h4000);

    // R5: service sequence
    do_reset();
    setup(64'd1000, 64'h0, 32'h80, 32'hB);
    arm();
    repeat (10) @(posedge clk);
    for (int k = 0; k < 2; k++) begin
      bus_wr(8'h28, key_word(KEY_OPEN, 1'b1));
      bus_rd(8'h10, r);
      bus_rd(8'h10, r2);
      check("R5", "counts during service", r2, r + 32'd1);
      bus_wr(8'h28, key_word(KEY_COMMIT, 1'b1));
      bus_rd(8'h10, r);
      check("R5", "commit clears count", r, 32'h0);
      bus_rd(8'h10, r);
      check("R5", "count resumes", r, 32'h1);
    end
    bus_rd(8'h28, r); check("R5", "still active", r, 32'h4000);
    check("R5", "no req after service", {31'h0, sys_rst_req}, 32'h0);

    // R8 / R9: timeout cycle, pulse length, absorbing state
    do_reset();
    setup(64'd20, 64'h0, 32'h80, 32'hB);
    arm();
    first = 0;
    for (int n = 1; n <= 100; n++) begin
      @(posedge clk); #1;
      if (sys_rst_req) begin first = n; break; end
    end
    check("R8", "expiry edge after arm", first, 32'd21);
    hi = 1;
    repeat (20) begin
      @(posedge clk); #1;
      if (sys_rst_req) hi++;
    end
    check("R9", "pulse length", hi, PULSE);
    bus_rd(8'h28, r);  check("R8", "flag and enable", r, 32'hC000);
    bus_rd(8'h10, r);  check("R8", "count holds at limit", r, 32'd20);
    arm();
    bus_wr(8'h18, 32'h9);
    hi = 0;
    repeat (10) begin
      @(posedge clk); #1;
      if (sys_rst_req) hi++;
    end
    check("R9", "no second pulse", hi, 0);
    bus_rd(8'h18, r);  check("R9", "expired ignores writes", r, 32'd20);
    bus_rd(8'h28, r);  check("R9", "still expired", r, 32'hC000);
    do_reset();
    bus_rd(8'h28, r);  check("R1", "reset leaves expiry", r, 32'h0);

    // R8: expiry beats a commit key in the same cycle
    do_reset();
    setup(64'd1, 64'h0, 32'h80, 32'hB);
    arm();
    bus_wr(8'h28, key_word(KEY_OPEN, 1'b1));
    bus_wr(8'h28, key_word(KEY_COMMIT, 1'b1));
    check("R8", "expiry wins over commit", {31'h0, sys_rst_req}, 32'h1);

    // R7: keys out of turn
    do_reset();
    setup(64'd5000, 64'h0, 32'h80, 32'hB);
    bus_wr(8'h28, key_word(KEY_OPEN, 1'b1));
    bus_wr(8'h28, key_word(16'h1234, 1'b1));
    check("R7", "bad key when opened", {31'h0, sys_rst_req}, 32'h1);
    bus_rd(8'h28, r); check("R7", "flag after bad key", r, 32'hC000);

    do_reset();
    setup(64'd5000, 64'h0, 32'h80, 32'hB);
    arm();
    bus_wr(8'h28, key_word(KEY_COMMIT, 1'b1));
    check("R7", "commit when active", {31'h0, sys_rst_req}, 32'h1);

    do_reset();
    setup(64'd5000, 64'h0, 32'h80, 32'hB);
    arm();
    bus_wr(8'h28, key_word(KEY_OPEN, 1'b1));
    bus_wr(8'h28, key_word(KEY_OPEN, 1'b1));
    check("R7", "open key during service", {31'h0, sys_rst_req}, 32'h1);

    report();
    $finish;
  end

endmodule